// File: doc/BRIEF.md
# Two-Path Serial Control Word Receiver

This block takes a three-wire host programming stream and turns it into held control codes for a controller that sets phase and amplitude on two RF paths. A 14-bit word is shifted in one bit per rising edge of the serial clock. A load strobe then passes the word into one of two stored channel registers, and a select bit inside the word picks which one. Path A keeps only a 5-bit phase code. Path B keeps a 5-bit phase code, a 4-bit attenuation code and a 3-bit loss-trim code. The bits shifted in come back out on a serial echo pin, delayed, so the host can confirm what it sent.

When the load strobe is high, the selected register is transparent and follows the shift register. When the strobe is low, shifting goes on with no effect on the stored codes. An asynchronous active-low reset loads power-up defaults, chosen by a default-pick input that is read only while reset is held. A high port-off input forces every output code to zero and freezes the stored registers. When the input is released, the stored codes appear on the outputs again.

Top module: `pac_ctl_if`

## Requirements
- R1: Word bit k is the k-th bit shifted in. The layout is: bits 1:0 are trim bits T0,T1; bits 6:2 are the phase code (LSB at bit 2); bits 10:7 are the attenuation code (LSB at bit 7); bit 11 is trim bit T2; bit 12 is a spare bit; bit 13 is the channel select. Path B trim is output as {T2,T1,T0}.
- R2: Select bit 0 loads only path A phase. Select bit 1 loads only path B phase, attenuation and trim.
- R3: While the load strobe is low, shifting does not change any output.
- R4: While the load strobe is high, the selected register follows the shift register after every clock edge. When the strobe falls, the register holds the last word.
- R5: The serial echo changes on the falling clock edge. At each rising edge it shows the data bit sampled 14 rising edges earlier. After reset the echo is zero until 14 bits have passed.
- R6: When reset is applied with default-pick low, every output code is zero.
- R7: When reset is applied with default-pick high, path A phase is 10000, path B phase is 10000, path B attenuation is 1111 and path B trim is 000.
- R8: Changing default-pick after reset has no effect on the outputs.
- R9: While port-off is high, all four output codes are zero, and load strobes do not change the stored registers.
- R10: When port-off falls, the outputs show again the codes that were stored before it rose.
- R11: The spare bit has no effect. Path A takes nothing from a word with select 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ser_clk_i | input | 1 | Serial clock; data sampled on rising edge |
| ser_din_i | input | 1 | Serial data in |
| ld_strobe_i | input | 1 | Load strobe; high makes selected register transparent |
| port_off_i | input | 1 | High forces zero codes and freezes stored registers |
| dflt_pick_i | input | 1 | Default-set choice, read during reset |
| ser_echo_o | output | 1 | Delayed echo of serial data, updated on falling edge |
| a_phase_o | output | 5 | Path A phase code |
| b_phase_o | output | 5 | Path B phase code |
| b_atten_o | output | 4 | Path B attenuation code |
| b_trim_o | output | 3 | Path B loss-trim code |

## Verification
The clocked properties sample on rising serial-clock edges, so they assume two things. Between two consecutive rising edges, the load strobe and port-off levels change only while the serial clock is idle. Neither level is pulsed twice inside one clock interval. The stimulus raises and lowers the strobe and port-off only between edges or with the clock stopped, and never toggles port-off while the strobe is high. Default-pick moves only while reset is held, or later only to show that the move has no effect.

// File: rtl/pac_ctl_pkg.sv
package pac_ctl_pkg;

   // Default field widths of the programming word
   localparam int PAC_PH_W  = 5;   // phase code
   localparam int PAC_AT_W  = 4;   // attenuation code
   localparam int PAC_TL_W  = 2;   // low trim bits at the word bottom
   localparam int PAC_TH_W  = 2;   // high trim bit plus spare bit

   // Channel select encoding carried in the top word bit
   typedef enum logic {
      PAC_PATH_A = 1'b0,
      PAC_PATH_B = 1'b1
   } pac_path_e;

endpackage

// File: rtl/pac_shift.sv
module pac_shift #(
   parameter int  W            = 14,
   parameter bit  ECHO_ON_FALL = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         din_i,
   output logic [W-1:0] word_o,
   output logic         echo_o
);

   if (W < 2) begin : g_bad_w
      $error("pac_shift: W must be at least 2");
   end

   logic [W-1:0] sr_q;

   // New bit enters at the top and moves toward bit 0
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {din_i, sr_q[W-1:1]};
   end

   assign word_o = sr_q;

   if (ECHO_ON_FALL) begin : g_echo_fall
      logic echo_q;
      always_ff @(negedge clk_i or negedge rst_ni) begin
         if (!rst_ni) echo_q <= 1'b0;
         else         echo_q <= sr_q[0];
      end
      assign echo_o = echo_q;

      // R5: echo shows the stage that sat one above the exit at the last edge
      p_echo_lag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         echo_o == $past(sr_q[1]))
         else $error("p_echo_lag_r5");
   end else begin : g_echo_rise
      logic echo_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) echo_q <= 1'b0;
         else         echo_q <= sr_q[0];
      end
      assign echo_o = echo_q;
   end

endmodule

// File: rtl/pac_chan_hold.sv
module pac_chan_hold #(
   parameter int           W      = 5,
   parameter logic [W-1:0] DEF_LO = '0,
   parameter logic [W-1:0] DEF_HI = '0
) (
   input  logic         rst_ni,
   input  logic         pick_i,
   input  logic         en_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("pac_chan_hold: W must be positive");
   end

   // Level-sensitive store: transparent while enabled, default during reset
   always_latch begin
      if (!rst_ni)   q_o <= pick_i ? DEF_HI : DEF_LO;
      else if (en_i) q_o <= d_i;
   end

endmodule

// File: rtl/pac_out_gate.sv
module pac_out_gate #(
   parameter int           W        = 5,
   parameter logic [W-1:0] OFF_CODE = '0
) (
   input  logic         off_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_bad_w
      $error("pac_out_gate: W must be positive");
   end

   always_comb begin
      q_o = off_i ? OFF_CODE : d_i;
   end

endmodule

// File: rtl/pac_ctl_if.sv
module pac_ctl_if
   import pac_ctl_pkg::*;
#(
   parameter int PH_W       = PAC_PH_W,
   parameter int AT_W       = PAC_AT_W,
   parameter int TL_W       = PAC_TL_W,
   parameter int TH_W       = PAC_TH_W,
   parameter int A_PH_PICK1 = 16,
   parameter int B_PH_PICK1 = 16,
   parameter int B_AT_PICK1 = 15,
   parameter bit ECHO_FALL  = 1'b1
) (
   input  logic            rst_ni,
   input  logic            ser_clk_i,
   input  logic            ser_din_i,
   input  logic            ld_strobe_i,
   input  logic            port_off_i,
   input  logic            dflt_pick_i,
   output logic            ser_echo_o,
   output logic [PH_W-1:0] a_phase_o,
   output logic [PH_W-1:0] b_phase_o,
   output logic [AT_W-1:0] b_atten_o,
   output logic [TL_W:0]   b_trim_o
);

   localparam int TRIM_W  = TL_W + 1;
   localparam int WORD_W  = TL_W + PH_W + AT_W + TH_W + 1;
   localparam int PH_LSB  = TL_W;
   localparam int AT_LSB  = PH_LSB + PH_W;
   localparam int TH_LSB  = AT_LSB + AT_W;
   localparam int SEL_BIT = TH_LSB + TH_W;
   localparam int B_W     = AT_W + PH_W + TRIM_W;

   localparam logic [PH_W-1:0] A_DEF1 = PH_W'(A_PH_PICK1);
   localparam logic [B_W-1:0]  B_DEF1 = {AT_W'(B_AT_PICK1), PH_W'(B_PH_PICK1), TRIM_W'(0)};

   if (TH_W < 2) begin : g_bad_th
      $error("pac_ctl_if: TH_W must hold the high trim bit and a spare");
   end
   if (A_PH_PICK1 >= (1 << PH_W) || B_PH_PICK1 >= (1 << PH_W)) begin : g_bad_ph_def
      $error("pac_ctl_if: phase default does not fit PH_W");
   end
   if (B_AT_PICK1 >= (1 << AT_W)) begin : g_bad_at_def
      $error("pac_ctl_if: attenuation default does not fit AT_W");
   end

   logic [WORD_W-1:0] word;
   logic              load_ok;
   logic              en_a, en_b;
   logic [PH_W-1:0]   a_d, a_q;
   logic [B_W-1:0]    b_d, b_q, b_out;
   pac_path_e         sel;

   pac_shift #(.W(WORD_W), .ECHO_ON_FALL(ECHO_FALL)) u_shift (
      .clk_i  (ser_clk_i),
      .rst_ni (rst_ni),
      .din_i  (ser_din_i),
      .word_o (word),
      .echo_o (ser_echo_o)
   );

   assign sel     = pac_path_e'(word[SEL_BIT]);
   assign load_ok = ld_strobe_i & ~port_off_i;
   assign en_a    = load_ok & (sel == PAC_PATH_A);
   assign en_b    = load_ok & (sel == PAC_PATH_B);

   assign a_d = word[PH_LSB +: PH_W];
   assign b_d = {word[AT_LSB +: AT_W], word[PH_LSB +: PH_W],
                 word[TH_LSB], word[TL_W-1:0]};

   logic [TH_W-2:0] unused_spare;
   assign unused_spare = word[SEL_BIT-1:TH_LSB+1];

   pac_chan_hold #(.W(PH_W), .DEF_LO('0), .DEF_HI(A_DEF1)) u_hold_a (
      .rst_ni (rst_ni),
      .pick_i (dflt_pick_i),
      .en_i   (en_a),
      .d_i    (a_d),
      .q_o    (a_q)
   );

   pac_chan_hold #(.W(B_W), .DEF_LO('0), .DEF_HI(B_DEF1)) u_hold_b (
      .rst_ni (rst_ni),
      .pick_i (dflt_pick_i),
      .en_i   (en_b),
      .d_i    (b_d),
      .q_o    (b_q)
   );

   pac_out_gate #(.W(PH_W), .OFF_CODE('0)) u_gate_a (
      .off_i (port_off_i),
      .d_i   (a_q),
      .q_o   (a_phase_o)
   );

   pac_out_gate #(.W(B_W), .OFF_CODE('0)) u_gate_b (
      .off_i (port_off_i),
      .d_i   (b_q),
      .q_o   (b_out)
   );

   assign b_atten_o = b_out[B_W-1 -: AT_W];
   assign b_phase_o = b_out[TRIM_W +: PH_W];
   assign b_trim_o  = b_out[TRIM_W-1:0];

   // R9: outputs read zero whenever the port is switched off
   p_off_zero_r9: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
      port_off_i |-> (a_phase_o == '0 && b_phase_o == '0 &&
                      b_atten_o == '0 && b_trim_o == '0))
      else $error("p_off_zero_r9");

   // R9: stored registers do not move while the port stays off
   p_off_frozen_r9: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
      (port_off_i && $past(port_off_i)) |-> ($stable(a_q) && $stable(b_q)))
      else $error("p_off_frozen_r9");

   // R4: with the strobe high, path A follows the phase field of a select-0 word
   p_follow_a_r4: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
      (ld_strobe_i && !port_off_i && !word[SEL_BIT]) |-> a_q == word[PH_LSB +: PH_W])
      else $error("p_follow_a_r4");

   // R2: a select-1 word held through an interval leaves path A untouched
   p_steer_b_r2: assert property (@(posedge ser_clk_i) disable iff (!rst_ni)
      (ld_strobe_i && $past(ld_strobe_i) && word[SEL_BIT] && $past(word[SEL_BIT]))
         |-> $stable(a_q))
      else $error("p_steer_b_r2");

endmodule

// File: tb/pac_ctl_if_bench.sv
module pac_ctl_if_bench;

   localparam int CLK_PERIOD = 20;
   localparam int Q = CLK_PERIOD / 4;

   logic       rst_ni = 1'b0, ser_clk_i = 1'b0, ser_din_i = 1'b0;
   logic       ld_strobe_i = 1'b0, port_off_i = 1'b0, dflt_pick_i = 1'b0;
   logic       ser_echo_o;
   logic [4:0] a_phase_o, b_phase_o;
   logic [3:0] b_atten_o;
   logic [2:0] b_trim_o;

   pac_ctl_if u_pac_ctl_if (
      .rst_ni, .ser_clk_i, .ser_din_i, .ld_strobe_i, .port_off_i, .dflt_pick_i,
      .ser_echo_o, .a_phase_o, .b_phase_o, .b_atten_o, .b_trim_o
   );

   typedef struct {
      logic [4:0] a_ph;
      logic [4:0] b_ph;
      logic [3:0] b_at;
      logic [2:0] b_tr;
      string      req;
   } exp_t;

   exp_t   sb_q[$];
   logic   echo_q[$];
   event   ev_chk;
   int     n_chk = 0, n_fail = 0;
   bit     finished = 1'b0;

   // bench model of the requirement-level state
   logic [13:0] m_sr;
   logic [4:0]  m_a_ph, m_b_ph;
   logic [3:0]  m_b_at;
   logic [2:0]  m_b_tr;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // R4 / R2 model: transparent store of the selected channel
   task automatic model_latch();
      if (ld_strobe_i && !port_off_i) begin
         if (m_sr[13]) begin
            m_b_at = m_sr[10:7];
            m_b_ph = m_sr[6:2];
            m_b_tr = {m_sr[11], m_sr[1:0]};
         end else begin
            m_a_ph = m_sr[6:2];
         end
      end
   endtask

   task automatic expect_now(input string req);
      exp_t e;
      e.a_ph = port_off_i ? 5'd0 : m_a_ph;
      e.b_ph = port_off_i ? 5'd0 : m_b_ph;
      e.b_at = port_off_i ? 4'd0 : m_b_at;
      e.b_tr = port_off_i ? 3'd0 : m_b_tr;
      e.req  = req;
      sb_q.push_back(e);
      ->ev_chk;
      #2;
   endtask

   // monitor: pops expected items and compares with the ports
   initial begin
      forever begin
         @(ev_chk);
         #1;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(a_phase_o == e.a_ph, e.req, "a_phase", a_phase_o, e.a_ph);
            chk(b_phase_o == e.b_ph, e.req, "b_phase", b_phase_o, e.b_ph);
            chk(b_atten_o == e.b_at, e.req, "b_atten", b_atten_o, e.b_at);
            chk(b_trim_o  == e.b_tr, e.req, "b_trim",  b_trim_o,  e.b_tr);
         end
      end
   end

   task automatic clk_bit(input logic b, input bit look);
      logic ex;
      ex = echo_q.pop_front();
      chk(ser_echo_o == ex, "R5", "echo", ser_echo_o, ex);
      echo_q.push_back(b);
      ser_din_i = b;
      #Q;
      ser_clk_i = 1'b1;
      m_sr = {b, m_sr[13:1]};
      #1;
      model_latch();
      if (look) expect_now("R4");
      else #2;
      #(2*Q - 3);
      ser_clk_i = 1'b0;
      #Q;
   endtask

   task automatic send_word(input logic [13:0] w, input bit look);
      for (int i = 0; i < 14; i++) clk_bit(w[i], look);
   endtask

   task automatic strobe();
      #Q;
      ld_strobe_i = 1'b1;
      model_latch();
      #(2*Q);
      ld_strobe_i = 1'b0;
      #Q;
   endtask

   task automatic do_reset(input logic pick);
      rst_ni = 1'b0;
      dflt_pick_i = pick;
      #CLK_PERIOD;
      rst_ni = 1'b1;
      #CLK_PERIOD;
      m_sr   = '0;
      m_a_ph = pick ? 5'b10000 : 5'b0;
      m_b_ph = pick ? 5'b10000 : 5'b0;
      m_b_at = pick ? 4'b1111  : 4'b0;
      m_b_tr = 3'b000;
      echo_q.delete();
      for (int i = 0; i < 14; i++) echo_q.push_back(1'b0);
   endtask

   // R1 field layout: {sel, spare, T2, atten[3:0], phase[4:0], T1, T0}
   function automatic logic [13:0] mk(input logic sel, input logic spare,
                                      input logic [2:0] trim, input logic [3:0] att,
                                      input logic [4:0] ph);
      return {sel, spare, trim[2], att, ph, trim[1:0]};
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      chk(1'b0, "watchdog", "timeout", 0, 1);
      finish_up();
   end

   initial begin
      do_reset(1'b0);
      expect_now("R6");
      do_reset(1'b1);
      expect_now("R7");
      dflt_pick_i = 1'b0;
      #CLK_PERIOD;
      expect_now("R8");

      send_word(mk(1'b0, 1'b0, 3'b000, 4'b0000, 5'b10101), 1'b0);
      expect_now("R3");
      strobe();
      expect_now("R1 R2 path A");

      send_word(mk(1'b1, 1'b0, 3'b101, 4'b1010, 5'b01101), 1'b0);
      expect_now("R3");
      strobe();
      expect_now("R1 R2 path B");

      send_word(mk(1'b1, 1'b1, 3'b010, 4'b0101, 5'b00011), 1'b0);
      strobe();
      expect_now("R11");

      port_off_i = 1'b1;
      #Q;
      expect_now("R9");
      send_word(mk(1'b0, 1'b0, 3'b000, 4'b0000, 5'b11111), 1'b0);
      strobe();
      expect_now("R9");
      send_word(mk(1'b1, 1'b0, 3'b111, 4'b1111, 5'b11111), 1'b0);
      strobe();
      expect_now("R9");
      port_off_i = 1'b0;
      #Q;
      expect_now("R10");

      ld_strobe_i = 1'b1;
      model_latch();
      #Q;
      expect_now("R4");
      send_word(mk(1'b1, 1'b0, 3'b100, 4'b0110, 5'b11010), 1'b1);
      ld_strobe_i = 1'b0;
      #Q;
      expect_now("R4");

      send_word(mk(1'b0, 1'b1, 3'b111, 4'b1111, 5'b00100), 1'b0);
      strobe();
      expect_now("R2 R11");

      send_word(14'h0000, 1'b0);
      expect_now("R3");
      #CLK_PERIOD;
      finish_up();
   end

endmodule